// File: doc/BRIEF.md
# Address-Coupled Register File

This block holds the working registers of a processor datapath in three banks of eight: wide operand registers, narrow address registers and narrow index registers. Software-visible writes and reads go through one write port and one read port. Writing an address register can also move data: some address registers start a memory load into the operand register with the same number. Others start a memory store from that operand register. The address written is the memory address. Address register 0 and operand register 0 are not coupled in this way. Index register 0 is a constant zero.

Memory traffic goes through a single-word request/acknowledge port, and only one transfer is outstanding at a time. A coupled address write that arrives while the port is busy is refused through `wr_ready`, and the caller retries it. Each load-coupled operand register shows a pending flag while its load is in flight. Reading a pending operand register raises `rd_stall`, so the consumer can hold until the data has arrived. A store takes its data from the operand register in the same cycle the address is written.

Top module: `coupled_regfile`

## Requirements
- R1: After reset every register in all three banks reads zero, `mem_req` is 0, `op_busy` is 0 and `wr_ready` is 1.
- R2: The bank select is 0 for operand, 1 for address, 2 for index and 3 for none. A write accepted with a bank select of 0, 1 or 2 updates that register, and a read returns it in the next cycle. Address and index values are zero-extended on read. Writes with bank select 3 change nothing, and reads with it return zero.
- R3: Index register 0 always reads zero, and writes to it have no effect.
- R4: An accepted write of value V to address register n, for n from 1 to 5, makes `mem_req`=1, `mem_we`=0 and `mem_addr`=V in the next cycle. On the edge where `mem_ack` is seen, operand register n takes `mem_rdata`, and address register n keeps V.
- R5: An accepted write to address register 6 or 7 makes `mem_req`=1 and `mem_we`=1 in the next cycle. `mem_wdata` is the operand register 6 or 7 value from the cycle of the address write. A later write to that operand register does not change `mem_wdata`.
- R6: Writes to address register 0, and to any operand or index register, start no memory request.
- R7: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. After a cycle with `mem_ack`=1, `mem_req` is 0.
- R8: While a request is outstanding, a write to address register 1 to 7 sees `wr_ready`=0 and has no effect: no register changes and no new request starts. All other writes see `wr_ready`=1.
- R9: `op_busy[n]` is 1 from the cycle after a load into operand register n is issued until the cycle after its acknowledge. A read of operand register n during that time raises `rd_stall`. At most one `op_busy` bit is set, and any set bit means a load is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request |
| wr_bank | input | 2 | Write bank: 0 operand, 1 address, 2 index, 3 none |
| wr_idx | input | 3 | Register number within the bank |
| wr_data | input | 60 | Write value; the low 18 bits are used for the address and index banks |
| wr_ready | output | 1 | Low when a coupled address write is refused because the memory port is busy |
| rd_bank | input | 2 | Read bank, encoded like wr_bank |
| rd_idx | input | 3 | Read register number |
| rd_data | output | 60 | Read value, zero-extended for narrow banks |
| rd_stall | output | 1 | Read targets an operand register whose load is pending |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a store, 0 for a load |
| mem_addr | output | 18 | Word address |
| mem_wdata | output | 60 | Store data |
| mem_ack | input | 1 | Transfer completes on this edge |
| mem_rdata | input | 60 | Load data, valid with mem_ack |
| op_busy | output | 8 | Pending-load flag for each operand register |

## Verification
Corrupted request state shows on the memory port in the cycle after the address write: a wrong address, a wrong direction or a missing request. Corrupted pending state shows at once on `op_busy` and `rd_stall`. A load that fills the wrong operand register shows only when that register is read. The bench reads it back at random, within a few cycles. A store captured too late shows as `mem_wdata` taking the later operand value while the request is still waiting for its acknowledge.

// File: rtl/crf_pkg.sv
package crf_pkg;
   typedef enum logic [1:0] {
      BANK_X    = 2'd0,
      BANK_A    = 2'd1,
      BANK_B    = 2'd2,
      BANK_NONE = 2'd3
   } bank_e;

   function automatic logic in_span(input int v, input int lo, input int hi);
      return (v >= lo) && (v <= hi);
   endfunction
endpackage

// File: rtl/crf_bank.sv
module crf_bank #(
   parameter int  W     = 60,
   parameter int  N     = 8,
   parameter bit  ZERO0 = 1'b0,
   localparam int IW    = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [IW-1:0]   widx,
   input  logic [W-1:0]    wdata,
   input  logic            fill_en,
   input  logic [IW-1:0]   fill_idx,
   input  logic [W-1:0]    fill_data,
   output logic [N*W-1:0]  q
);
   if (N < 2) begin : g_bad_n
      $error("crf_bank needs at least two registers");
   end

   for (genvar g = 0; g < N; g++) begin : g_reg
      if (ZERO0 && g == 0) begin : g_const
         assign q[g*W +: W] = '0;
      end else begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[g*W +: W] <= '0;
            else if (fill_en && fill_idx == IW'(g))
               q[g*W +: W] <= fill_data;
            else if (we && widx == IW'(g))
               q[g*W +: W] <= wdata;
         end
      end
   end
endmodule

// File: rtl/crf_mem_ctrl.sv
module crf_mem_ctrl #(
   parameter int  DW      = 60,
   parameter int  AW      = 18,
   parameter int  N       = 8,
   parameter int  LOAD_LO = 1,
   parameter int  LOAD_HI = 5,
   localparam int IW      = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           issue,
   input  logic [IW-1:0]  issue_idx,
   input  logic [AW-1:0]  issue_addr,
   input  logic [DW-1:0]  store_data,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic           mem_ack,
   input  logic [DW-1:0]  mem_rdata,
   output logic           fill_en,
   output logic [IW-1:0]  fill_idx,
   output logic [DW-1:0]  fill_data,
   output logic [N-1:0]   pend
);
   import crf_pkg::*;

   logic [IW-1:0] cur_idx;
   logic          issue_load;

   assign issue_load = in_span(int'(issue_idx), LOAD_LO, LOAD_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         cur_idx   <= '0;
         pend      <= '0;
      end else begin
         if (mem_req && mem_ack) begin
            mem_req <= 1'b0;
            pend    <= '0;
         end
         if (issue) begin
            mem_req   <= 1'b1;
            mem_we    <= !issue_load;
            mem_addr  <= issue_addr;
            mem_wdata <= store_data;
            cur_idx   <= issue_idx;
            pend      <= issue_load ? (N'(1) << issue_idx) : '0;
         end
      end
   end

   assign fill_en   = mem_req && mem_ack && !mem_we;
   assign fill_idx  = cur_idx;
   assign fill_data = mem_rdata;

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
   // R7
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && !issue) |=> !mem_req);
   // R9
   pend_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pend));
   // R9
   pend_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|pend) |-> (mem_req && !mem_we));
endmodule

// File: rtl/coupled_regfile.sv
module coupled_regfile
   import crf_pkg::*;
#(
   parameter int  DW       = 60,
   parameter int  AW       = 18,
   parameter int  NREG     = 8,
   parameter int  LOAD_LO  = 1,
   parameter int  LOAD_HI  = 5,
   parameter int  STORE_LO = 6,
   parameter int  STORE_HI = 7,
   localparam int IW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_bank,
   input  logic [IW-1:0]   wr_idx,
   input  logic [DW-1:0]   wr_data,
   output logic            wr_ready,
   input  logic [1:0]      rd_bank,
   input  logic [IW-1:0]   rd_idx,
   output logic [DW-1:0]   rd_data,
   output logic            rd_stall,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_ack,
   input  logic [DW-1:0]   mem_rdata,
   output logic [NREG-1:0] op_busy
);
   if (AW > DW) begin : g_bad_w
      $error("address width must not exceed data width");
   end
   if (LOAD_LO < 1 || LOAD_HI >= STORE_LO || STORE_HI >= NREG) begin : g_bad_map
      $error("coupling ranges must be ordered, skip register 0 and fit the bank");
   end

   logic [NREG*DW-1:0] x_q;
   logic [NREG*AW-1:0] a_q, b_q;
   logic               wr_coupled, accept, issue;
   logic               fill_en;
   logic [IW-1:0]      fill_idx;
   logic [DW-1:0]      fill_data;
   logic [DW-1:0]      store_data;

   assign wr_coupled = wr_en && (wr_bank == BANK_A) &&
                       (in_span(int'(wr_idx), LOAD_LO, LOAD_HI) ||
                        in_span(int'(wr_idx), STORE_LO, STORE_HI));
   assign wr_ready   = !(wr_coupled && mem_req);
   assign accept     = wr_en && wr_ready;
   assign issue      = accept && wr_coupled;
   assign store_data = x_q[wr_idx*DW +: DW];

   crf_bank #(.W(DW), .N(NREG), .ZERO0(1'b0)) u_xbank (
      .clk, .rst_n,
      .we(accept && wr_bank == BANK_X), .widx(wr_idx), .wdata(wr_data),
      .fill_en, .fill_idx, .fill_data, .q(x_q));

   crf_bank #(.W(AW), .N(NREG), .ZERO0(1'b0)) u_abank (
      .clk, .rst_n,
      .we(accept && wr_bank == BANK_A), .widx(wr_idx), .wdata(wr_data[AW-1:0]),
      .fill_en(1'b0), .fill_idx('0), .fill_data('0), .q(a_q));

   crf_bank #(.W(AW), .N(NREG), .ZERO0(1'b1)) u_bbank (
      .clk, .rst_n,
      .we(accept && wr_bank == BANK_B), .widx(wr_idx), .wdata(wr_data[AW-1:0]),
      .fill_en(1'b0), .fill_idx('0), .fill_data('0), .q(b_q));

   crf_mem_ctrl #(.DW(DW), .AW(AW), .N(NREG), .LOAD_LO(LOAD_LO), .LOAD_HI(LOAD_HI)) u_ctrl (
      .clk, .rst_n,
      .issue, .issue_idx(wr_idx), .issue_addr(wr_data[AW-1:0]), .store_data,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
      .fill_en, .fill_idx, .fill_data, .pend(op_busy));

   always_comb begin
      rd_data = '0;
      case (rd_bank)
         BANK_X:  rd_data = x_q[rd_idx*DW +: DW];
         BANK_A:  rd_data = DW'(a_q[rd_idx*AW +: AW]);
         BANK_B:  rd_data = DW'(b_q[rd_idx*AW +: AW]);
         default: rd_data = '0;
      endcase
   end

   assign rd_stall = (rd_bank == BANK_X) && op_busy[rd_idx];

   // R3
   bzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_bank == BANK_B && rd_idx == '0) |-> (rd_data == '0));
   // R9
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stall |-> (mem_req && !mem_we));
endmodule

// File: tb/tb_coupled_regfile.sv
module tb_coupled_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_bank = '0;
   logic [2:0]  wr_idx = '0;
   logic [59:0] wr_data = '0;
   logic        wr_ready;
   logic [1:0]  rd_bank = '0;
   logic [2:0]  rd_idx = '0;
   logic [59:0] rd_data;
   logic        rd_stall;
   logic        mem_req, mem_we;
   logic [17:0] mem_addr;
   logic [59:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [59:0] mem_rdata;
   logic [7:0]  op_busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [59:0] mem_word(input logic [17:0] a);
      return {a[5:0] ^ 6'h2a, a, ~a, a};
   endfunction

   assign mem_rdata = mem_word(mem_addr);

   coupled_regfile dut (.*);

   // bench reference state
   logic [59:0] xm [8];
   logic [17:0] am [8];
   logic [17:0] bm [8];
   logic        out_v, out_we;
   logic [2:0]  out_i;
   logic [17:0] out_a;
   logic [59:0] out_d;

   task automatic chk(input bit ok, input string tag, input logic [59:0] act, input logic [59:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [59:0] exp_rd(input logic [1:0] b, input logic [2:0] i);
      case (b)
         2'd0:    return xm[i];
         2'd1:    return {42'b0, am[i]};
         2'd2:    return (i == 0) ? 60'b0 : {42'b0, bm[i]};
         default: return 60'b0;
      endcase
   endfunction

   function automatic bit coupled_in();
      return wr_en && wr_bank == 2'd1 && wr_idx != 3'd0;
   endfunction

   // one clock: inputs are already set just after the previous edge
   task automatic cyc();
      bit          rdy;
      logic [7:0]  eb;
      #2;
      rdy = !(coupled_in() && out_v);
      chk(wr_ready == rdy, "R8 wr_ready", 60'(wr_ready), 60'(rdy));
      chk(rd_data == exp_rd(rd_bank, rd_idx),
          (rd_bank == 2'd2 && rd_idx == 0) ? "R3 index0 read" : "R2 read",
          rd_data, exp_rd(rd_bank, rd_idx));
      chk(rd_stall == (rd_bank == 2'd0 && out_v && !out_we && out_i == rd_idx),
          "R9 rd_stall", 60'(rd_stall), 60'(rd_bank == 2'd0 && out_v && !out_we && out_i == rd_idx));
      @(posedge clk);
      if (out_v && mem_ack) begin
         if (!out_we) xm[out_i] = mem_word(out_a);
         out_v = 1'b0;
      end
      if (wr_en && rdy) begin
         if (coupled_in()) begin
            out_v  = 1'b1;
            out_we = (wr_idx >= 3'd6);
            out_i  = wr_idx;
            out_a  = wr_data[17:0];
            out_d  = xm[wr_idx];
         end
         case (wr_bank)
            2'd0: xm[wr_idx] = wr_data;
            2'd1: am[wr_idx] = wr_data[17:0];
            2'd2: if (wr_idx != 0) bm[wr_idx] = wr_data[17:0];
            default: ;
         endcase
      end
      #1;
      chk(mem_req == out_v, "R6 R7 mem_req", 60'(mem_req), 60'(out_v));
      if (out_v) begin
         chk(mem_we == out_we, out_we ? "R5 mem_we" : "R4 mem_we", 60'(mem_we), 60'(out_we));
         chk(mem_addr == out_a, "R4 R5 mem_addr", 60'(mem_addr), 60'(out_a));
         if (out_we) chk(mem_wdata == out_d, "R5 mem_wdata", mem_wdata, out_d);
      end
      eb = (out_v && !out_we) ? (8'd1 << out_i) : 8'd0;
      chk(op_busy == eb, "R9 op_busy", 60'(op_busy), 60'(eb));
   endtask

   task automatic set_wr(input bit en, input logic [1:0] b, input logic [2:0] i, input logic [59:0] d);
      wr_en = en; wr_bank = b; wr_idx = i; wr_data = d;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 8; i++) begin xm[i] = '0; am[i] = '0; bm[i] = '0; end
      out_v = 0; out_we = 0; out_i = 0; out_a = 0; out_d = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1: reset state, every register of every bank
      chk(mem_req == 1'b0 && op_busy == 8'd0, "R1 port idle", 60'({mem_req, op_busy}), 60'd0);
      chk(wr_ready == 1'b1, "R1 wr_ready", 60'(wr_ready), 60'd1);
      for (int b = 0; b < 3; b++)
         for (int i = 0; i < 8; i++) begin
            rd_bank = 2'(b); rd_idx = 3'(i); #1;
            chk(rd_data == 60'd0, "R1 reg zero", rd_data, 60'd0);
         end

      // R3: index register 0 ignores writes
      set_wr(1, 2'd2, 3'd0, 60'h3ffff); rd_bank = 2'd2; rd_idx = 3'd0; cyc();
      set_wr(0, 0, 0, 0); cyc();
      chk(rd_data == 60'd0, "R3 index0 after write", rd_data, 60'd0);
      // R2: plain writes, zero-extension, bank 3 ignored
      set_wr(1, 2'd2, 3'd3, 60'hfff_ffff_fff2_1234); cyc();
      set_wr(1, 2'd0, 3'd2, 60'h0123_4567_89ab_cde); rd_idx = 3'd3; cyc();
      set_wr(1, 2'd3, 3'd2, 60'hfff); rd_bank = 2'd0; rd_idx = 3'd2; cyc();
      set_wr(0, 0, 0, 0); rd_bank = 2'd0; cyc();
      chk(rd_data == 60'h0123_4567_89ab_cde, "R2 bank3 write ignored", rd_data, 60'h0123_4567_89ab_cde);
      // R6: uncoupled writes start nothing
      set_wr(1, 2'd1, 3'd0, 60'h777); cyc();
      set_wr(1, 2'd0, 3'd0, 60'h5); cyc();
      set_wr(0, 0, 0, 0); cyc();
      chk(mem_req == 1'b0, "R6 no request", 60'(mem_req), 60'd0);

      // R4 / R7 / R8 / R9: load into operand 3, held for three cycles
      set_wr(1, 2'd1, 3'd3, 60'h123); cyc();
      chk(mem_req && !mem_we && mem_addr == 18'h123, "R4 load issue", 60'(mem_addr), 60'h123);
      set_wr(1, 2'd1, 3'd5, 60'h999); rd_bank = 2'd0; rd_idx = 3'd3; cyc();
      set_wr(0, 0, 0, 0); rd_bank = 2'd1; rd_idx = 3'd5; cyc();
      chk(rd_data == 60'd0, "R8 refused write", rd_data, 60'd0);
      mem_ack = 1'b1; cyc();
      mem_ack = 1'b0; rd_bank = 2'd0; rd_idx = 3'd3; cyc();
      chk(rd_data == mem_word(18'h123), "R4 load data", rd_data, mem_word(18'h123));
      chk(mem_req == 1'b0 && op_busy == 8'd0, "R7 R9 idle after ack", 60'({mem_req, op_busy}), 60'd0);

      // R5: store from operand 6, data captured at address write
      set_wr(1, 2'd0, 3'd6, 60'haaaa_bbbb_cccc_ddd); cyc();
      set_wr(1, 2'd1, 3'd6, 60'h55); cyc();
      set_wr(1, 2'd0, 3'd6, 60'h1); cyc();
      set_wr(0, 0, 0, 0); cyc();
      chk(mem_we && mem_wdata == 60'haaaa_bbbb_cccc_ddd, "R5 store data", mem_wdata, 60'haaaa_bbbb_cccc_ddd);
      mem_ack = 1'b1; cyc();
      mem_ack = 1'b0; cyc();

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [2:0] idx;
         logic [1:0] bk;
         idx = 3'($urandom % 8);
         bk  = 2'($urandom % 4);
         mem_ack = out_v && ($urandom % 3 == 0);
         if (bk == 2'd0 && out_v && !out_we && idx == out_i)
            set_wr(0, 0, 0, 0);
         else
            set_wr(($urandom % 2) == 1, bk, idx, {28'($urandom), 32'($urandom)});
         rd_bank = 2'($urandom % 4);
         rd_idx  = 3'($urandom % 8);
         cyc();
      end
      mem_ack = 1'b0;
      set_wr(0, 0, 0, 0);
      finish_run();
   end
endmodule